// File: doc/BRIEF.md
# Voice Amplitude Envelope Generator

This block shapes the loudness of one synthesizer voice over time. It moves through four phases: attack, decay, sustain and release. On every sample tick it advances a 16-bit level register. A single 32-bit control word sets the phase speeds, curve shapes and the sustain threshold. The voice logic starts a note with a key-on strobe and ends it with a key-off strobe. Software may also overwrite the level directly.

Each phase speed is a 7-bit rate code. The code splits into two parts:
- an integer step added to the level;
- an increment for a 15-bit fractional divider, which decides on which ticks the step is applied.

Exponential increase slows down once the level passes 0x6000. Exponential decrease scales the step by the current level. A global enable input mutes the voice on every tick while it is low.

Top module: `env_generator`

## Requirements
- R1: While reset is asserted, the level reads 0 and the phase reads release. Phase codes are attack 0, decay 1, sustain 2, release 3.
- R2: Control word fields:
  - sustain threshold code in bits 3:0;
  - decay rate in bits 7:4;
  - attack rate in bits 14:8, attack exponential in bit 15;
  - release rate in bits 20:16, release exponential in bit 21;
  - sustain rate in bits 28:22, sustain decreasing in bit 30, sustain exponential in bit 31.
  
  The decay and release rates in use are their fields times 4. The sustain threshold is (code+1)<<11.
- R3: Step and divider increment from a rate r:
  - The step is 7-(r&3), bitwise inverted for decreasing phases.
  - If r<0x2C, the step is shifted left by (0x2F-r)>>2.
  - The divider increment is 32768. If r>=0x30, it is shifted right by (r-0x2C)>>2.
- R4: Exponential curves:
  - Exponential decrease uses (signed level × step)>>15 as the step.
  - Exponential increase with a signed level of at least 0x6000 changes by rate: below 0x28 the step is quartered; at 0x2C or above the divider increment is quartered; in between both are halved.
- R5: Each tick adds the increment to the divider. When divider bit 15 becomes set, the divider clears and the step is added to the level. An increment of 0 is raised to 1 when the rate is below the phase maximum (0x7F for attack and sustain, 0x7C for decay and release). At attack rate 0x7F the level therefore stays frozen.
- R6: In attack, a 0-to-1 change of level bit 15 on a step forces 0x7FFF. A tick that starts in attack with the level at 0x7FFF runs as decay.
- R7: Decay always decreases exponentially. It enters sustain when a step leaves the level below the sustain threshold.
- R8: Outside attack, a step that leaves bit 15 set replaces the level with 0, or with 0x7FFF for an increasing sustain.
- R9: Key-on is applied after any step in the same cycle. It clears the level and the divider and enters attack. It wins over a simultaneous key-off.
- R10: Key-off clears the divider and enters release, except when the phase after the step is already release. In that case the divider keeps counting.
- R11: On a tick with the global enable low, the block ends in release with level 0, after key strobes are applied. With enable low and no tick, nothing changes.
- R12: A level write sets the level seen in the next cycle, overriding every other level update in that cycle. Later ticks continue from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | 32 | Packed envelope control word |
| key_on | input | 1 | Start-of-note strobe |
| key_off | input | 1 | End-of-note strobe |
| tick | input | 1 | Sample-rate step strobe |
| gbl_en | input | 1 | Global enable; low mutes on ticks |
| lvl_wr | input | 1 | Direct level write strobe |
| lvl_wdata | input | 16 | Value for a direct level write |
| level | output | 16 | Current envelope level |
| phase | output | 2 | Current phase code |

## Verification
The exponential-increase knee is the hardest case to reach from the ports. The level must sit at or above 0x6000 while still in attack, with a rate in each of the three slowdown bands. A slow attack would take thousands of ticks to climb there. The stimulus therefore writes a level just below 0x6000 after key-on and then ticks across the knee, once for a rate in each band. A second hard case is a key-off that arrives while already in release: the only visible sign that the divider was left alone is when the next step lands. The bench checks this against a behavioural model on every clock.

// File: rtl/env_pkg.sv
package env_pkg;
    parameter int LVL_W  = 16;
    parameter int DIV_W  = 16;
    parameter int RATE_W = 7;
    parameter int CTL_W  = 32;
    parameter int STEP_W = 32;

    localparam logic [LVL_W-1:0]  LVL_TOP   = LVL_W'(16'h7FFF);
    localparam logic [LVL_W-1:0]  LVL_KNEE  = LVL_W'(16'h6000);
    localparam logic [RATE_W-1:0] RMAX_FULL = RATE_W'(7'h7F);
    localparam logic [RATE_W-1:0] RMAX_QUAD = RATE_W'(7'h7C);

    typedef enum logic [1:0] {
        PH_ATK = 2'd0,
        PH_DEC = 2'd1,
        PH_SUS = 2'd2,
        PH_REL = 2'd3
    } env_phase_e;

    typedef struct packed {
        logic       sus_exp;
        logic       sus_down;
        logic       spare;
        logic [6:0] sus_rate;
        logic       rel_exp;
        logic [4:0] rel_rate;
        logic       atk_exp;
        logic [6:0] atk_rate;
        logic [3:0] dec_rate;
        logic [3:0] sus_code;
    } env_ctl_t;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic [DIV_W-1:0] div;
        env_phase_e       phase;
    } env_state_t;
endpackage

// File: rtl/env_phase_sel.sv
module env_phase_sel
    import env_pkg::*;
(
    input  logic [CTL_W-1:0]  ctl_word,
    input  env_phase_e        ph,
    output logic [RATE_W-1:0] rate,
    output logic              exp_mode,
    output logic              dec_mode,
    output logic [RATE_W-1:0] rate_max,
    output logic [LVL_W-1:0]  ovf_val,
    output logic [LVL_W-1:0]  sus_thr
);
    env_ctl_t c;
    assign c = env_ctl_t'(ctl_word);

    // Threshold = (code + 1) << 11
    assign sus_thr = LVL_W'(({1'b0, c.sus_code} + 5'd1)) << 11;

    always_comb begin
        rate     = '0;
        exp_mode = 1'b0;
        dec_mode = 1'b0;
        rate_max = RMAX_FULL;
        ovf_val  = '0;
        unique case (ph)
            PH_ATK: begin
                rate     = c.atk_rate;
                exp_mode = c.atk_exp;
                dec_mode = 1'b0;
                rate_max = RMAX_FULL;
                ovf_val  = LVL_TOP;
            end
            PH_DEC: begin
                rate     = RATE_W'({c.dec_rate, 2'b00});
                exp_mode = 1'b1;
                dec_mode = 1'b1;
                rate_max = RMAX_QUAD;
                ovf_val  = '0;
            end
            PH_SUS: begin
                rate     = c.sus_rate;
                exp_mode = c.sus_exp;
                dec_mode = c.sus_down;
                rate_max = RMAX_FULL;
                ovf_val  = c.sus_down ? '0 : LVL_TOP;
            end
            default: begin
                rate     = RATE_W'({c.rel_rate, 2'b00});
                exp_mode = c.rel_exp;
                dec_mode = 1'b1;
                rate_max = RMAX_QUAD;
                ovf_val  = '0;
            end
        endcase
    end
endmodule

// File: rtl/env_rate_step.sv
module env_rate_step
    import env_pkg::*;
(
    input  logic [RATE_W-1:0]        rate,
    input  logic                     exp_mode,
    input  logic                     dec_mode,
    input  logic [LVL_W-1:0]         level,
    input  logic [RATE_W-1:0]        rate_max,
    output logic signed [STEP_W-1:0] step,
    output logic [DIV_W-1:0]         div_inc
);
    localparam int EXT = STEP_W - LVL_W;

    logic [2:0]               base;
    logic signed [STEP_W-1:0] lvl_s;
    logic signed [STEP_W-1:0] st;
    logic signed [STEP_W-1:0] prod;
    logic [STEP_W-1:0]        dv;
    logic [RATE_W-1:0]        lsh;
    logic [RATE_W-1:0]        rsh;

    assign base  = 3'd7 - {1'b0, rate[1:0]};
    assign lvl_s = {{EXT{level[LVL_W-1]}}, level};
    assign lsh   = (RATE_W'(7'h2F) - rate) >> 2;
    assign rsh   = (rate - RATE_W'(7'h2C)) >> 2;

    always_comb begin
        st = signed'(STEP_W'(base));
        if (dec_mode)
            st = ~st;
        dv = STEP_W'(32'h8000);
        if (rate < RATE_W'(7'h2C))
            st = st <<< lsh;
        if (rate >= RATE_W'(7'h30))
            dv = dv >> rsh;
        prod = lvl_s * st;
        if (exp_mode) begin
            if (dec_mode) begin
                st = prod >>> 15;
            end else if (!level[LVL_W-1] && level >= LVL_KNEE) begin
                if (rate < RATE_W'(7'h28)) begin
                    st = st >>> 2;
                end else if (rate >= RATE_W'(7'h2C)) begin
                    dv = dv >> 2;
                end else begin
                    st = st >>> 1;
                    dv = dv >> 1;
                end
            end
        end
        if (dv == '0 && rate < rate_max)
            dv = STEP_W'(1);
    end

    assign step    = st;
    assign div_inc = dv[DIV_W-1:0];
endmodule

// File: rtl/env_level_apply.sv
module env_level_apply
    import env_pkg::*;
(
    input  logic [LVL_W-1:0]         level_in,
    input  logic [DIV_W-1:0]         div_in,
    input  env_phase_e               ph,
    input  logic signed [STEP_W-1:0] step,
    input  logic [DIV_W-1:0]         div_inc,
    input  logic [LVL_W-1:0]         ovf_val,
    input  logic [LVL_W-1:0]         sus_thr,
    output logic [LVL_W-1:0]         level_out,
    output logic [DIV_W-1:0]         div_out,
    output env_phase_e               ph_out
);
    logic [DIV_W-1:0] acc;
    logic [LVL_W-1:0] sum;
    logic             wrap;

    assign acc = div_in + div_inc;
    assign sum = level_in + step[LVL_W-1:0];

    always_comb begin
        level_out = level_in;
        div_out   = acc;
        ph_out    = ph;
        wrap      = 1'b0;
        if (acc[DIV_W-1]) begin
            div_out = '0;
            if (ph == PH_ATK)
                wrap = !level_in[LVL_W-1] && sum[LVL_W-1];
            else
                wrap = sum[LVL_W-1];
            level_out = wrap ? ovf_val : sum;
            if (ph == PH_DEC && level_out < sus_thr)
                ph_out = PH_SUS;
        end
    end
endmodule

// File: rtl/env_generator.sv
module env_generator
    import env_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ctl_word,
    input  logic        key_on,
    input  logic        key_off,
    input  logic        tick,
    input  logic        gbl_en,
    input  logic        lvl_wr,
    input  logic [15:0] lvl_wdata,
    output logic [15:0] level,
    output logic [1:0]  phase
);
    env_state_t st_q, st_d;

    env_phase_e               ph_eff;
    logic [RATE_W-1:0]        rate;
    logic                     exp_mode;
    logic                     dec_mode;
    logic [RATE_W-1:0]        rate_max;
    logic [LVL_W-1:0]         ovf_val;
    logic [LVL_W-1:0]         sus_thr;
    logic signed [STEP_W-1:0] step;
    logic [DIV_W-1:0]         div_inc;
    logic [LVL_W-1:0]         lvl_stp;
    logic [DIV_W-1:0]         div_stp;
    env_phase_e               ph_stp;

    // A tick starting at the top of attack runs as decay.
    assign ph_eff = (st_q.phase == PH_ATK && st_q.level == LVL_TOP) ? PH_DEC : st_q.phase;

    env_phase_sel u_sel (
        .ctl_word (ctl_word),
        .ph       (ph_eff),
        .rate     (rate),
        .exp_mode (exp_mode),
        .dec_mode (dec_mode),
        .rate_max (rate_max),
        .ovf_val  (ovf_val),
        .sus_thr  (sus_thr)
    );

    env_rate_step u_rate (
        .rate     (rate),
        .exp_mode (exp_mode),
        .dec_mode (dec_mode),
        .level    (st_q.level),
        .rate_max (rate_max),
        .step     (step),
        .div_inc  (div_inc)
    );

    env_level_apply u_apply (
        .level_in  (st_q.level),
        .div_in    (st_q.div),
        .ph        (ph_eff),
        .step      (step),
        .div_inc   (div_inc),
        .ovf_val   (ovf_val),
        .sus_thr   (sus_thr),
        .level_out (lvl_stp),
        .div_out   (div_stp),
        .ph_out    (ph_stp)
    );

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.level = lvl_stp;
            st_d.div   = div_stp;
            st_d.phase = ph_stp;
        end
        if (key_off && st_d.phase != PH_REL) begin
            st_d.div   = '0;
            st_d.phase = PH_REL;
        end
        if (key_on) begin
            st_d.level = '0;
            st_d.div   = '0;
            st_d.phase = PH_ATK;
        end
        if (tick && !gbl_en) begin
            st_d.level = '0;
            st_d.phase = PH_REL;
        end
        if (lvl_wr)
            st_d.level = lvl_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level <= '0;
            st_q.div   <= '0;
            st_q.phase <= PH_REL;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.level;
    assign phase = st_q.phase;
endmodule

// File: rtl/env_generator_chk.sv
module env_generator_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        key_on,
    input logic        key_off,
    input logic        tick,
    input logic        gbl_en,
    input logic        lvl_wr,
    input logic [15:0] lvl_wdata,
    input logic [15:0] level,
    input logic [1:0]  phase
);
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (level == 16'h0000 && phase == 2'd3));

    assert_keyon_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (key_on && !lvl_wr && (gbl_en || !tick)) |=> (phase == 2'd0 && level == 16'h0000));

    assert_keyoff_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (key_off && !key_on) |=> (phase == 2'd3));

    assert_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_wr |=> (level == $past(lvl_wdata)));

    assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !key_on && !key_off && !lvl_wr) |=> ($stable(level) && $stable(phase)));

    assert_mute_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !gbl_en && !lvl_wr) |=> (level == 16'h0000 && phase == 2'd3));

    assert_atk_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && gbl_en && phase == 2'd0 && level == 16'h7FFF && !key_on && !key_off && !lvl_wr)
        |=> (phase == 2'd1 || phase == 2'd2));

    assert_rel_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && phase == 2'd3 && !level[15] && !key_on && !lvl_wr) |=> (level <= $past(level)));
endmodule

bind env_generator env_generator_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_on    (key_on),
    .key_off   (key_off),
    .tick      (tick),
    .gbl_en    (gbl_en),
    .lvl_wr    (lvl_wr),
    .lvl_wdata (lvl_wdata),
    .level     (level),
    .phase     (phase)
);

// File: tb/sim_env_generator.sv
`timescale 1ns/1ps
module sim_env_generator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctl_word = '0;
    logic        key_on = 1'b0, key_off = 1'b0, tick = 1'b0, gbl_en = 1'b1, lvl_wr = 1'b0;
    logic [15:0] lvl_wdata = '0;
    logic [15:0] level;
    logic [1:0]  phase;

    always #4 clk = ~clk;

    env_generator u0 (
        .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .key_on(key_on), .key_off(key_off),
        .tick(tick), .gbl_en(gbl_en), .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata),
        .level(level), .phase(phase)
    );

    int    n_vec = 0, n_bad = 0;
    bit    done = 1'b0;
    string req = "R1";
    int    m_lvl = 0, m_div = 0, m_ph = 3;

    function automatic int mk_ctl(int sl, int dr, int ar, int ae, int rr, int re, int sr, int sd, int se);
        return (sl & 15) | ((dr & 15) << 4) | ((ar & 127) << 8) | ((ae & 1) << 15) |
               ((rr & 31) << 16) | ((re & 1) << 21) | ((sr & 127) << 22) |
               ((sd & 1) << 30) | ((se & 1) << 31);
    endfunction

    // Behavioural reference of one clock.
    task automatic model(input bit t, input bit kon, input bit koff, input bit en, input bit wr, input int wd);
        int c, rate, ex, dn, zm, rv, thr, inc, dinc, cur, prev, sh;
        c = int'(ctl_word);
        if (t) begin
            if (m_ph == 0 && m_lvl == 32767) m_ph = 1;
            thr = (((c & 15) + 1) << 11);
            case (m_ph)
                0: begin rate = (c >> 8) & 127; ex = (c >> 15) & 1; dn = 0; zm = 127; rv = 32767; end
                1: begin rate = ((c >> 4) & 15) * 4; ex = 1; dn = 1; zm = 124; rv = 0; end
                2: begin rate = (c >> 22) & 127; ex = (c >>> 31) & 1; dn = (c >> 30) & 1; zm = 127;
                         rv = dn ? 0 : 32767; end
                default: begin rate = ((c >> 16) & 31) * 4; ex = (c >> 21) & 1; dn = 1; zm = 124; rv = 0; end
            endcase
            cur = (m_lvl >= 32768) ? m_lvl - 65536 : m_lvl;
            inc = 7 - (rate % 4);
            if (dn) inc = -inc - 1;
            dinc = 32768;
            if (rate < 44) begin sh = (47 - rate) / 4; inc = inc * (1 << sh); end
            if (rate >= 48) begin sh = (rate - 44) / 4; dinc = (sh > 20) ? 0 : (dinc >> sh); end
            if (ex) begin
                if (dn) inc = (cur * inc) >>> 15;
                else if (cur >= 24576) begin
                    if (rate < 40) inc = inc / 4;
                    else if (rate >= 44) dinc = dinc / 4;
                    else begin inc = inc / 2; dinc = dinc / 2; end
                end
            end
            if (dinc == 0 && rate < zm) dinc = 1;
            m_div = m_div + dinc;
            if (m_div >= 32768) begin
                m_div = 0;
                prev = m_lvl;
                m_lvl = (m_lvl + inc) & 65535;
                if (m_ph == 0) begin
                    if (prev < 32768 && m_lvl >= 32768) m_lvl = rv;
                end else if (m_lvl >= 32768) m_lvl = rv;
                if (m_ph == 1 && m_lvl < thr) m_ph = 2;
            end
        end
        if (koff && m_ph != 3) begin m_div = 0; m_ph = 3; end
        if (kon) begin m_lvl = 0; m_div = 0; m_ph = 0; end
        if (t && !en) begin m_lvl = 0; m_ph = 3; end
        if (wr) m_lvl = wd & 65535;
    endtask

    task automatic compare();
        n_vec++;
        if (int'(level) !== m_lvl || int'(phase) !== m_ph) begin
            n_bad++;
            $display("FAIL %s: level/phase got %h/%0d expected %h/%0d at %0t",
                     req, level, phase, m_lvl[15:0], m_ph, $time);
        end
    endtask

    task automatic cyc(input bit t, input bit kon, input bit koff, input bit en, input bit wr, input int wd);
        tick = t; key_on = kon; key_off = koff; gbl_en = en; lvl_wr = wr; lvl_wdata = wd[15:0];
        @(posedge clk);
        if (rst_n) model(t, kon, koff, en, wr, wd);
        @(negedge clk);
        tick = 0; key_on = 0; key_off = 0; lvl_wr = 0;
        compare();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 1, 0, 0);
    endtask

    // Check that the block reaches a given phase code.
    task automatic expect_phase(input int p);
        n_vec++;
        if (int'(phase) != p) begin
            n_bad++;
            $display("FAIL %s: phase got %0d expected %0d", req, phase, p);
        end
    endtask

    initial begin
        @(negedge clk);
        req = "R1";
        m_lvl = 0; m_div = 0; m_ph = 3;
        compare();
        cyc(1, 1, 0, 1, 0, 0);   // ignored during reset
        rst_n = 1'b1;
        cyc(0, 0, 0, 1, 0, 0);

        // R2 R3 R6 R7 R8 R10: full linear note
        req = "R2/R3/R6/R7";
        ctl_word = mk_ctl(7, 3, 16, 0, 5, 0, 48, 1, 1);
        cyc(0, 1, 0, 1, 0, 0);
        ticks(800);
        expect_phase(2);
        req = "R10";
        cyc(1, 0, 1, 1, 0, 0);
        expect_phase(3);
        req = "R8";
        ticks(3000);

        // R4 exponential increase knee, three bands, starting near 0x6000
        req = "R4 band<0x28";
        ctl_word = mk_ctl(15, 15, 8'h20, 1, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 1, 16'h5F00);
        ticks(300);
        req = "R4 band 0x28-0x2B";
        ctl_word = mk_ctl(15, 15, 8'h2A, 1, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 1, 16'h5FF0);
        ticks(1500);
        req = "R4 band>=0x2C";
        ctl_word = mk_ctl(15, 15, 8'h34, 1, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 1, 16'h5FF8);
        ticks(1500);

        // R5 frozen attack at rate 0x7F, and slow divided rate
        req = "R5";
        ctl_word = mk_ctl(0, 0, 8'h7F, 0, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 1, 16'h1234);
        ticks(200);
        ctl_word = mk_ctl(0, 0, 8'h40, 0, 0, 0, 0, 0, 0);
        ticks(200);

        // R6 R8 increasing sustain, threshold 0x8000 enters sustain at once
        req = "R8 rising sustain";
        ctl_word = mk_ctl(15, 0, 0, 0, 0, 0, 8'h10, 0, 1);
        cyc(0, 1, 0, 1, 0, 0);
        ticks(600);
        expect_phase(2);
        cyc(0, 0, 0, 1, 1, 16'h7FF0);
        ticks(20);

        // R8 exponential release, R10 key-off in release keeps divider
        req = "R10 keyoff in release";
        ctl_word = mk_ctl(0, 0, 0, 0, 16, 1, 0, 0, 0);
        cyc(1, 0, 1, 1, 0, 0);
        cyc(0, 0, 0, 1, 1, 16'h4000);
        ticks(5);
        cyc(0, 0, 1, 1, 0, 0);
        ticks(40);
        cyc(0, 0, 1, 1, 0, 0);
        ticks(200);

        // R9 sparse ticks; key-on with tick; key-on beats key-off
        req = "R9";
        ctl_word = mk_ctl(3, 8, 8'h24, 0, 2, 0, 8'h30, 0, 0);
        for (int k = 0; k < 40; k++) begin
            cyc(0, 0, 0, 1, 0, 0);
            cyc(0, 0, 0, 1, 0, 0);
            cyc(1, (k % 13) == 5, 0, 1, 0, 0);
        end
        cyc(1, 1, 0, 1, 0, 0);
        cyc(0, 1, 1, 1, 0, 0);
        expect_phase(0);
        ticks(300);

        // R11 enable low: no tick -> no effect; tick -> mute
        req = "R11";
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0);
        expect_phase(3);
        cyc(0, 1, 0, 1, 0, 0);
        ticks(50);

        // R12 write with bit 15 set in release; write beats key-on
        req = "R12";
        ctl_word = mk_ctl(0, 0, 0, 0, 10, 0, 0, 0, 0);
        cyc(0, 0, 1, 1, 0, 0);
        cyc(0, 0, 0, 1, 1, 16'h9000);
        ticks(30);
        cyc(1, 1, 0, 1, 1, 16'h0777);
        ticks(30);
        cyc(1, 0, 0, 0, 1, 16'h0555);
        ticks(20);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, got no end expected end");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule